// File: doc/BRIEF.md
# Four-Instruction Multi-Cycle Processor Core

This block is a very small sequential processor. It has four 10-bit general registers, a 4-bit program counter and one zero flag. It executes a four-instruction set: a branch taken while the zero flag is clear, a three-register add, a load and a store. Code and data share one external 16-word by 10-bit memory, and only the program decides which words hold code and which hold data. Every memory access uses two bus cycles. In the first cycle the core drives the address together with a read or write strobe. In the second cycle the data moves and both strobes are low.

The core executes one instruction at a time, with no overlap between instructions. After reset it fetches from the address on `start_pc`, so a program can keep its data in the low words. A taken branch to its own address parks the core in a halted state and raises `halted`. The surrounding logic can then read the results back out of memory.

The controller has seven states:
- BOOT is the reset state.
- FETCH_A is the address cycle of an instruction fetch.
- FETCH_D is the data cycle of an instruction fetch. It captures the instruction and advances the PC.
- EXEC decodes the instruction, completes an add or a branch, and chooses the next state.
- MEM_A is the address cycle of a load or store.
- MEM_D is the data cycle of a load or store.
- HALT is the parked state.

The transitions are:
- BOOT→FETCH_A
- FETCH_A→FETCH_D→EXEC
- EXEC→FETCH_A for an add or a branch
- EXEC→MEM_A for a load or store
- EXEC→HALT for a taken branch to its own address
- MEM_A→MEM_D→FETCH_A
- HALT→HALT

Top module: `mini_core`

## Requirements
- R1: While reset is asserted, the core clears all four registers and the zero flag, loads the PC from `start_pc`, and holds both strobes and `halted` low. The first fetch after reset reads address `start_pc`.
- R2: Each access drives `bus_rd` or `bus_wr` in its address cycle, never both. In the following data cycle both strobes are low and `bus_addr` keeps its value.
- R3: An add or a branch takes 3 clocks: fetch address, fetch data, execute. A load or store takes 5 clocks, adding its own address and data cycles.
- R4: Opcode bits [9:8] = 01 is add. The destination register is bits [5:4] (bits [7:6] are ignored), source A is bits [3:2] and source B is bits [1:0]. The 10-bit sum wraps modulo 1024, so 1023 acts as -1.
- R5: An add sets the zero flag when its 10-bit sum is zero and clears it otherwise. No load, store or branch changes the flag.
- R6: Opcode 00 is a branch with its target in bits [7:4]. When the zero flag is 0 the PC takes the target. When the flag is 1 execution falls through to the next word.
- R7: Opcode 10 is a load. It reads memory address bits [3:0] into the register in bits [5:4]. The read data is taken at the end of the data cycle.
- R8: Opcode 11 is a store. It writes the register in bits [1:0] to memory address bits [7:4], driving `bus_wdata` during the data cycle.
- R9: A taken branch whose target equals its own address moves the core to HALT. From then on `halted` stays high and neither strobe is raised again until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pc | input | 4 | First instruction address after reset |
| bus_rdata | input | 10 | Read data from memory, valid in the data cycle |
| bus_addr | output | 4 | Memory address, held across both bus cycles |
| bus_rd | output | 1 | Read strobe, high in the address cycle only |
| bus_wr | output | 1 | Write strobe, high in the address cycle only |
| bus_wdata | output | 10 | Store data, driven in the data cycle |
| halted | output | 1 | Core has stopped on a self-branch |

## Verification
The bound checker watches four rules on every clock:
- the read and write strobes are never high together;
- every strobe is followed by a quiet data cycle with the address held;
- the zero flag changes only just after an add executes;
- a completed add or branch goes straight back to fetch.

It also checks that the halted state is permanent and silent. The arithmetic results cannot be seen that way, and neither can the branch direction or the use of each operand field. The bench shows those by running two counted-loop programs against a behavioural instruction-level model and reading the stored words back from memory. One of the two programs checks that a load between an add and a branch leaves the flag alone.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int WORD_W    = 10;
    localparam int ADDR_W    = 4;
    localparam int NUM_REGS  = 4;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int OPC_W     = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_BRNZ  = 2'b00,
        OP_ADD   = 2'b01,
        OP_LOAD  = 2'b10,
        OP_STORE = 2'b11
    } opcode_t;

    typedef enum logic [2:0] {
        S_BOOT,
        S_FETCH_A,
        S_FETCH_D,
        S_EXEC,
        S_MEM_A,
        S_MEM_D,
        S_HALT
    } state_t;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DW   = 10,
    parameter int NREG = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0]   regs [NREG];
    logic [NREG-1:0] wsel;

    for (genvar g = 0; g < NREG; g++) begin : g_wsel
        assign wsel[g] = we && (waddr == IW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wsel[i]) regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mc_adder.sv
module mc_adder #(
    parameter int DW = 10
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic          is_zero
);
    assign sum     = a + b;
    assign is_zero = (sum == '0);
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_pc,
    input  logic [WORD_W-1:0] rdata,
    input  logic              add_zero,
    output state_t            state,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] ir,
    output logic              zflag
);
    state_t            nxt;
    opcode_t           op;
    logic [ADDR_W-1:0] target;
    logic              take;
    logic              self_loop;

    assign op        = opcode_t'(ir[WORD_W-1 -: OPC_W]);
    assign target    = ir[WORD_W-OPC_W-1 -: ADDR_W];
    assign take      = (op == OP_BRNZ) && !zflag;
    assign self_loop = (target == ADDR_W'(pc - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_BOOT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_BOOT:    nxt = S_FETCH_A;
            S_FETCH_A: nxt = S_FETCH_D;
            S_FETCH_D: nxt = S_EXEC;
            S_EXEC: begin
                if (op == OP_LOAD || op == OP_STORE) nxt = S_MEM_A;
                else if (take && self_loop)          nxt = S_HALT;
                else                                 nxt = S_FETCH_A;
            end
            S_MEM_A:   nxt = S_MEM_D;
            S_MEM_D:   nxt = S_FETCH_A;
            S_HALT:    nxt = S_HALT;
            default:   nxt = S_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= start_pc;
            ir    <= '0;
            zflag <= 1'b0;
        end else begin
            if (state == S_FETCH_D) begin
                ir <= rdata;
                pc <= pc + 1'b1;
            end
            if (state == S_EXEC && op == OP_ADD) zflag <= add_zero;
            if (state == S_EXEC && take && !self_loop) pc <= target;
        end
    end
endmodule

// File: rtl/mini_core.sv
module mini_core
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_pc,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              halted
);
    state_t               state;
    logic [ADDR_W-1:0]    pc;
    logic [WORD_W-1:0]    ir;
    logic                 zflag;
    opcode_t              op;
    logic [ADDR_W-1:0]    mem_addr;
    logic [WORD_W-1:0]    src_a, src_b, sum;
    logic                 sum_zero;
    logic                 rf_we;
    logic [WORD_W-1:0]    rf_wdata;
    logic [REG_IDX_W-1:0] rf_waddr;

    assign op       = opcode_t'(ir[WORD_W-1 -: OPC_W]);
    assign mem_addr = (op == OP_LOAD) ? ir[ADDR_W-1:0] : ir[WORD_W-OPC_W-1 -: ADDR_W];
    assign rf_waddr = ir[2*REG_IDX_W +: REG_IDX_W];

    mc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_pc (start_pc),
        .rdata    (bus_rdata),
        .add_zero (sum_zero),
        .state    (state),
        .pc       (pc),
        .ir       (ir),
        .zflag    (zflag)
    );

    mc_regfile #(.DW(WORD_W), .NREG(NUM_REGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ir[REG_IDX_W +: REG_IDX_W]),
        .raddr_b (ir[0 +: REG_IDX_W]),
        .rdata_a (src_a),
        .rdata_b (src_b)
    );

    mc_adder #(.DW(WORD_W)) u_add (
        .a       (src_a),
        .b       (src_b),
        .sum     (sum),
        .is_zero (sum_zero)
    );

    always_comb begin
        bus_addr  = pc;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        rf_we     = 1'b0;
        rf_wdata  = sum;
        unique case (state)
            S_FETCH_A: bus_rd = 1'b1;
            S_EXEC:    rf_we  = (op == OP_ADD);
            S_MEM_A: begin
                bus_addr = mem_addr;
                bus_rd   = (op == OP_LOAD);
                bus_wr   = (op == OP_STORE);
            end
            S_MEM_D: begin
                bus_addr = mem_addr;
                if (op == OP_STORE) begin
                    bus_wdata = src_b;
                end else begin
                    rf_we    = 1'b1;
                    rf_wdata = bus_rdata;
                end
            end
            default: ;
        endcase
    end

    assign halted = (state == S_HALT);
endmodule

// File: rtl/mc_checker.sv
module mc_checker
    import mc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              halted,
    input logic              zflag,
    input state_t            st,
    input logic [OPC_W-1:0]  op
);
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_quiet_data_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> (!bus_rd && !bus_wr && $stable(bus_addr)));

    assert_flag_only_by_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(zflag) |-> ($past(st) == S_EXEC && $past(op) == OP_ADD));

    assert_short_instr_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EXEC && (op == OP_ADD || op == OP_BRNZ)) |=> (st == S_FETCH_A || st == S_HALT));

    assert_halt_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !bus_rd && !bus_wr));
endmodule

bind mini_core mc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .halted   (halted),
    .zflag    (zflag),
    .st       (state),
    .op       (ir[mc_pkg::WORD_W-1 -: mc_pkg::OPC_W])
);

// File: tb/tb_mini_core.sv
`timescale 1ns/1ps
module tb_mini_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] start_pc = 4'd0;
    logic [9:0] bus_rdata;
    logic [3:0] bus_addr;
    logic       bus_rd, bus_wr;
    logic [9:0] bus_wdata;
    logic       halted;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mini_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_pc  (start_pc),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .halted    (halted)
    );

    // behavioural memory following the two-cycle contract
    logic [9:0] mem [16];
    logic [3:0] rd_lat, wr_lat;
    logic       wr_pend;
    always @(posedge clk) begin
        if (bus_rd) rd_lat <= bus_addr;
        wr_pend <= bus_wr;
        wr_lat  <= bus_addr;
        if (wr_pend) mem[wr_lat] <= bus_wdata;
    end
    assign bus_rdata = mem[rd_lat];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] e_add(int d, int a, int b);
        return {2'b01, 4'(d), 2'(a), 2'(b)};
    endfunction
    function automatic logic [9:0] e_ld(int d, int a);
        return {2'b10, 4'(d), 4'(a)};
    endfunction
    function automatic logic [9:0] e_st(int a, int s);
        return {2'b11, 4'(a), 2'b00, 2'(s)};
    endfunction
    function automatic logic [9:0] e_br(int t);
        return {2'b00, 4'(t), 4'b0000};
    endfunction

    // instruction-level reference model advanced one clock at a time
    // phases: 0 boot, 1 fetch addr, 2 fetch data, 3 exec, 4 mem addr, 5 mem data, 6 halt
    int         m_ph;
    logic [3:0] m_pc;
    logic [9:0] m_ir;
    logic [9:0] m_reg [4];
    logic       m_z;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_ph = 0;
            m_pc = start_pc;
            m_ir = '0;
            m_z  = 1'b0;
            for (int i = 0; i < 4; i++) m_reg[i] = '0;
        end else begin
            logic [1:0]  op;
            logic [3:0]  maddr;
            logic [9:0]  s;
            op    = m_ir[9:8];
            maddr = (op == 2'b10) ? m_ir[3:0] : m_ir[7:4];
            chk("R2 read strobe", 16'(bus_rd), 16'(m_ph == 1 || (m_ph == 4 && op == 2'b10)));
            chk("R3 write strobe", 16'(bus_wr), 16'(m_ph == 4 && op == 2'b11));
            chk("R9 halted flag", 16'(halted), 16'(m_ph == 6));
            if (m_ph == 1 || m_ph == 2) chk("R6 fetch address", 16'(bus_addr), 16'(m_pc));
            if (m_ph == 4 || m_ph == 5) chk("R7 data address", 16'(bus_addr), 16'(maddr));
            if (m_ph == 5 && op == 2'b11) chk("R8 store data", 16'(bus_wdata), 16'(m_reg[m_ir[1:0]]));
            case (m_ph)
                0: m_ph = 1;
                1: m_ph = 2;
                2: begin m_ir = mem[m_pc]; m_pc = m_pc + 4'd1; m_ph = 3; end
                3: begin
                    case (op)
                        2'b01: begin
                            s = m_reg[m_ir[3:2]] + m_reg[m_ir[1:0]];
                            m_reg[m_ir[5:4]] = s;
                            m_z = (s == 10'd0);
                            m_ph = 1;
                        end
                        2'b00: begin
                            if (!m_z && m_ir[7:4] == 4'(m_pc - 4'd1)) m_ph = 6;
                            else begin
                                if (!m_z) m_pc = m_ir[7:4];
                                m_ph = 1;
                            end
                        end
                        default: m_ph = 4;
                    endcase
                end
                4: m_ph = 5;
                5: begin
                    if (op == 2'b10) m_reg[m_ir[5:4]] = mem[m_ir[3:0]];
                    m_ph = 1;
                end
                default: m_ph = 6;
            endcase
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 16; i++) mem[i] <= 10'd0;
    endtask

    task automatic run_prog(input logic [3:0] sp);
        logic seen;
        seen = 1'b0;
        start_pc = sp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 strobes low in reset", 16'({bus_rd, bus_wr}), 16'd0);
        chk("R1 halted low in reset", 16'(halted), 16'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (bus_rd && !seen) begin
                seen = 1'b1;
                chk("R1 first fetch address", 16'(bus_addr), 16'(sp));
            end
            if (halted) break;
        end
        chk("R9 program reached halt", 16'(halted), 16'd1);
        repeat (4) @(negedge clk);
        chk("R9 halt is sticky and silent", 16'({halted, bus_rd, bus_wr}), 16'b100);
    endtask

    initial begin
        // program 1: counted loop from word 4, data in words 0..3
        rst_n = 1'b0;
        clear_mem();
        mem[0]  <= 10'd1;
        mem[1]  <= 10'd5;
        mem[2]  <= 10'h3FF;
        mem[4]  <= e_ld(1, 0);
        mem[5]  <= e_ld(2, 1);
        mem[6]  <= e_ld(3, 2);
        mem[7]  <= e_add(0, 0, 1);
        mem[8]  <= e_add(2, 2, 3);
        mem[9]  <= e_br(7);
        mem[10] <= e_st(3, 0);
        mem[11] <= e_add(3, 3, 3);
        mem[12] <= e_st(2, 3);
        mem[13] <= e_br(13);
        run_prog(4'd4);
        chk("R6 loop result stored", 16'(mem[3]), 16'd5);
        chk("R4 wrapped sum stored", 16'(mem[2]), 16'd1022);

        // program 2: branch falls through while a load leaves the zero flag set
        rst_n = 1'b0;
        clear_mem();
        mem[0]  <= e_add(1, 0, 0);
        mem[1]  <= e_ld(2, 15);
        mem[2]  <= e_br(0);
        mem[3]  <= e_add(3, 2, 2);
        mem[4]  <= e_st(14, 3);
        mem[5]  <= e_br(5);
        mem[15] <= 10'd7;
        run_prog(4'd0);
        chk("R5 flag kept across load", 16'(mem[14]), 16'd14);
        chk("R7 loaded word untouched", 16'(mem[15]), 16'd7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL R3 watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule